// File: doc/BRIEF.md
# Two-Role Shared Bus Tenure Controller

This block decides when one on-chip master may drive a shared external bus. The bus uses three active-low handshake lines: request, grant and busy. A static role input sets how the block uses them. As the arbiter, it grants the bus to one external master and takes the bus for the chip when no external master is asking. As a requester, it asks an outside arbiter for the bus and begins only once the grant is qualified.

The local bus interface raises a need level. The block answers with an ownership level and a single-cycle active-low transfer-start strobe. The local side marks its last transfer with a done pulse, and busy is released one cycle later. When the chip is the default owner (parked), it starts without a request round-trip.

A separate guard watches transfers that an external master starts. It asserts burst inhibit for a burst aimed into the chip's internal memory window.

Top module: `bus_tenure_ctrl`

## Requirements
- R1: After reset, req_out_n, gnt_out_n, busy_out_n, start_n and burst_inh_n are all high, and busy_oe and loc_owner are low.
- R2: gnt_oe equals arb_internal and req_oe equals its inverse. busy_oe is high only while the chip holds the bus. req_in_n is ignored when arb_internal is 0, and gnt_in_n is ignored when arb_internal is 1.
- R3: Arbiter role, bus idle: a low req_in_n at a clock edge drives gnt_out_n low in the next cycle. This holds even when loc_need is high at the same edge.
- R4: Arbiter role: gnt_out_n stays high while the chip holds busy. A request still pending when busy is released is granted one cycle after the release.
- R5: Arbiter role: grant stays low until busy_in_n is seen low, then goes high. If req_in_n goes high first, grant goes high. During the external tenure the chip does not take the bus, even with loc_need high. The bus returns to idle at the edge where busy_in_n is seen high.
- R6: Arbiter role, idle, loc_need high, req_in_n high: the next cycle shows busy_out_n low, loc_owner high and start_n low.
- R7: Requester role: loc_need high without a qualified grant drives req_out_n low from the next cycle. req_out_n stays low until a qualified grant arrives or loc_need falls. A grant is qualified only when gnt_in_n is low and busy_in_n is high.
- R8: Requester role: the chip asserts busy only at the edge after a qualified grant is sampled. If the grant is already qualified while idle (parked), it starts in the next cycle and never lowers req_out_n.
- R9: start_n is low for exactly one cycle, in the first cycle of each chip tenure, and never outside one.
- R10: A high loc_last_done sampled while the chip owns the bus makes busy_out_n high in the next cycle.
- R11: In the cycle after an edge where ext_start_n is low, ext_burst is high, ext_addr is inside the internal window and the chip does not own the bus, burst_inh_n is low. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_internal | input | 1 | 1: block is the arbiter; 0: block requests from an outside arbiter |
| loc_need | input | 1 | Local interface wants the bus |
| loc_last_done | input | 1 | Local interface finished its last transfer |
| loc_owner | output | 1 | Chip currently owns the bus |
| req_in_n | input | 1 | Request line as seen on the bus |
| req_out_n | output | 1 | Request driven toward an outside arbiter |
| req_oe | output | 1 | Enable for req_out_n |
| gnt_in_n | input | 1 | Grant line from an outside arbiter |
| gnt_out_n | output | 1 | Grant driven to an external master |
| gnt_oe | output | 1 | Enable for gnt_out_n |
| busy_in_n | input | 1 | Busy line as seen on the bus |
| busy_out_n | output | 1 | Busy driven by the chip |
| busy_oe | output | 1 | Enable for busy_out_n |
| start_n | output | 1 | Transfer-start strobe of the chip |
| ext_start_n | input | 1 | Transfer start by an external master |
| ext_burst | input | 1 | External transfer is a burst |
| ext_addr | input | ADDR_W | External transfer address |
| burst_inh_n | output | 1 | Burst inhibit toward the external master |

## Verification
The bench builds the block with a 16-bit address and a 4 KiB internal window at 0x4000. This lets directed cases place addresses exactly on the window's first and last byte and one byte outside each side. Random phases run each role in turn, with all handshake lines toggled freely. Those phases reach the races between a chip need and an external request at the same edge, grants withdrawn before busy appears, and grants made unqualified by a foreign busy.

// File: rtl/bta_pkg.sv
package bta_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_OWN  = 3'd2,
        ST_GNT  = 3'd3,
        ST_EXT  = 3'd4
    } tenure_e;

    typedef struct packed {
        tenure_e st;
        logic    go;
    } fsm_regs_t;

endpackage

// File: rtl/bta_owner_fsm.sv
module bta_owner_fsm
    import bta_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    arb_internal,
    input  logic    ext_req,
    input  logic    ext_busy,
    input  logic    qual_gnt,
    input  logic    loc_need,
    input  logic    loc_last_done,
    output tenure_e st_q,
    output logic    go_q
);

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (arb_internal) begin
                    if (ext_req) begin
                        r_d.st = ST_GNT;
                    end else if (loc_need) begin
                        r_d.st = ST_OWN;
                        r_d.go = 1'b1;
                    end
                end else if (loc_need) begin
                    if (qual_gnt) begin
                        r_d.st = ST_OWN;
                        r_d.go = 1'b1;
                    end else begin
                        r_d.st = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (!loc_need) begin
                    r_d.st = ST_IDLE;
                end else if (qual_gnt) begin
                    r_d.st = ST_OWN;
                    r_d.go = 1'b1;
                end
            end
            ST_OWN: begin
                if (loc_last_done) r_d.st = ST_IDLE;
            end
            ST_GNT: begin
                if (ext_busy)      r_d.st = ST_EXT;
                else if (!ext_req) r_d.st = ST_IDLE;
            end
            ST_EXT: begin
                if (!ext_busy) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_IDLE;
            r_q.go <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q = r_q.st;
    assign go_q = r_q.go;

    AST_GNT_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OWN) |=> (st_q != ST_GNT)); // R4
    AST_EXT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXT && ext_busy) |=> (st_q == ST_EXT)); // R5
    AST_QUAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_internal && $rose(st_q == ST_OWN)) |-> $past(qual_gnt)); // R8
    AST_GO_IN_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |-> (st_q == ST_OWN)); // R9
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_q |=> !go_q); // R9
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OWN && loc_last_done) |=> (st_q != ST_OWN)); // R10

endmodule

// File: rtl/bta_burst_guard.sv
module bta_burst_guard #(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] INT_BASE = 32'h0040_0000,
    parameter int unsigned       WIN_LOG2 = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_start,
    input  logic              ext_burst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              chip_owner,
    output logic              inhibit_q
);

    localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;

    typedef struct packed {
        logic inh;
    } guard_regs_t;

    guard_regs_t g_d, g_q;
    logic        in_win;

    assign in_win = (ext_addr[ADDR_W-1:WIN_LOG2] == INT_BASE[ADDR_W-1:WIN_LOG2]);

    always_comb begin
        g_d     = g_q;
        g_d.inh = ext_start && ext_burst && in_win && !chip_owner;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q.inh <= 1'b0;
        else        g_q     <= g_d;
    end

    assign inhibit_q = g_q.inh;

    AST_BI_NOT_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        chip_owner |=> !inhibit_q); // R11
    AST_BI_SINGLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && !ext_burst) |=> !inhibit_q); // R11

    if (TAG_W < 1) begin : g_bad_win
        initial $error("window wider than address");
    end

endmodule

// File: rtl/bus_tenure_ctrl.sv
module bus_tenure_ctrl
    import bta_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] INT_BASE = 32'h0040_0000,
    parameter int unsigned       WIN_LOG2 = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_internal,
    input  logic              loc_need,
    input  logic              loc_last_done,
    output logic              loc_owner,
    input  logic              req_in_n,
    output logic              req_out_n,
    output logic              req_oe,
    input  logic              gnt_in_n,
    output logic              gnt_out_n,
    output logic              gnt_oe,
    input  logic              busy_in_n,
    output logic              busy_out_n,
    output logic              busy_oe,
    output logic              start_n,
    input  logic              ext_start_n,
    input  logic              ext_burst,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              burst_inh_n
);

    tenure_e st;
    logic    go;
    logic    ext_req, ext_busy, qual_gnt, inhibit;

    // Lines the block drives in the current role are masked off as inputs.
    assign ext_req  = arb_internal && !req_in_n;
    assign ext_busy = !busy_in_n;
    assign qual_gnt = !arb_internal && !gnt_in_n && busy_in_n;

    bta_owner_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .arb_internal  (arb_internal),
        .ext_req       (ext_req),
        .ext_busy      (ext_busy),
        .qual_gnt      (qual_gnt),
        .loc_need      (loc_need),
        .loc_last_done (loc_last_done),
        .st_q          (st),
        .go_q          (go)
    );

    bta_burst_guard #(
        .ADDR_W   (ADDR_W),
        .INT_BASE (INT_BASE),
        .WIN_LOG2 (WIN_LOG2)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_start  (!ext_start_n),
        .ext_burst  (ext_burst),
        .ext_addr   (ext_addr),
        .chip_owner (loc_owner),
        .inhibit_q  (inhibit)
    );

    assign loc_owner   = (st == ST_OWN);
    assign busy_out_n  = !loc_owner;
    assign busy_oe     = loc_owner;
    assign req_out_n   = !(st == ST_REQ);
    assign req_oe      = !arb_internal;
    assign gnt_out_n   = !(st == ST_GNT);
    assign gnt_oe      = arb_internal;
    assign start_n     = !go;
    assign burst_inh_n = !inhibit;

    AST_GNT_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!gnt_out_n && !busy_out_n)); // R4
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_oe && gnt_oe)); // R2
    AST_START_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        !start_n |-> !busy_out_n); // R9
    AST_REQ_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_out_n |-> req_oe); // R7

endmodule

// File: tb/bus_tenure_ctrl_test.sv
module bus_tenure_ctrl_test;

    localparam int PERIOD = 10;
    localparam int AW     = 16;
    localparam int S_IDLE = 0, S_REQ = 1, S_OWN = 2, S_GNT = 3, S_EXT = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic arb_internal = 1'b1, loc_need = 1'b0, loc_last_done = 1'b0;
    logic req_in_n = 1'b1, gnt_in_n = 1'b1, busy_in_n = 1'b1;
    logic ext_start_n = 1'b1, ext_burst = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic loc_owner, req_out_n, req_oe, gnt_out_n, gnt_oe, busy_out_n, busy_oe;
    logic start_n, burst_inh_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    int m_st = S_IDLE;
    bit m_go = 1'b0, m_bi = 1'b0;
    bit saw_req = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    bus_tenure_ctrl #(.ADDR_W(AW), .INT_BASE(16'h4000), .WIN_LOG2(12)) uut (.*);

    function automatic bit in_win(logic [AW-1:0] a);
        return (a >= 16'h4000) && (a <= 16'h4FFF);
    endfunction

    function automatic int nxt_st(int st, bit mi, bit rq, bit bz, bit gq, bit nd, bit ld);
        case (st)
            S_IDLE: if (mi) return rq ? S_GNT : (nd ? S_OWN : S_IDLE);
                    else    return nd ? (gq ? S_OWN : S_REQ) : S_IDLE;
            S_REQ:  return !nd ? S_IDLE : (gq ? S_OWN : S_REQ);
            S_OWN:  return ld ? S_IDLE : S_OWN;
            S_GNT:  return bz ? S_EXT : (!rq ? S_IDLE : S_GNT);
            default: return bz ? S_EXT : S_IDLE;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= S_IDLE; m_go <= 1'b0; m_bi <= 1'b0;
        end else begin
            automatic bit rq = arb_internal && !req_in_n;
            automatic bit gq = !arb_internal && !gnt_in_n && busy_in_n;
            automatic int n  = nxt_st(m_st, arb_internal, rq, !busy_in_n, gq, loc_need, loc_last_done);
            m_go <= (n == S_OWN) && (m_st != S_OWN);
            m_bi <= !ext_start_n && ext_burst && in_win(ext_addr) && (m_st != S_OWN);
            m_st <= n;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        chk(gnt_out_n == !(m_st == S_GNT), "R3 gnt_out_n", gnt_out_n, !(m_st == S_GNT));
        chk(req_out_n == !(m_st == S_REQ), "R7 req_out_n", req_out_n, !(m_st == S_REQ));
        chk(busy_out_n == !(m_st == S_OWN), "R10 busy_out_n", busy_out_n, !(m_st == S_OWN));
        chk(loc_owner == (m_st == S_OWN), "R6 loc_owner", loc_owner, m_st == S_OWN);
        chk(start_n == !m_go, "R9 start_n", start_n, !m_go);
        chk(burst_inh_n == !m_bi, "R11 burst_inh_n", burst_inh_n, !m_bi);
        chk(busy_oe == (m_st == S_OWN) && gnt_oe == arb_internal && req_oe == !arb_internal,
            "R2 enables", {busy_oe, gnt_oe, req_oe}, {m_st == S_OWN, arb_internal, !arb_internal});
        if (!req_out_n) saw_req = 1'b1;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic do_reset(bit mode);
        rst_n = 1'b0; arb_internal = mode;
        loc_need = 0; loc_last_done = 0; req_in_n = 1; gnt_in_n = 1; busy_in_n = 1;
        ext_start_n = 1; ext_burst = 0; ext_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all();
    endtask

    task automatic rand_run(bit mode, int n);
        do_reset(mode);
        for (int i = 0; i < n; i++) begin
            automatic int k = $urandom_range(0, 3);
            loc_need      = ($urandom_range(0, 3) != 0);
            loc_last_done = ($urandom_range(0, 4) == 0);
            req_in_n      = ($urandom_range(0, 2) == 0);
            gnt_in_n      = $urandom_range(0, 1);
            busy_in_n     = ($urandom_range(0, 3) != 0);
            ext_start_n   = $urandom_range(0, 1);
            ext_burst     = $urandom_range(0, 1);
            ext_addr      = (k == 0) ? 16'h4000 : (k == 1) ? 16'h4FFF :
                            (k == 2) ? 16'h3FFF : 16'h5000;
            if ($urandom_range(0, 3) == 0) ext_addr = 16'($urandom);
            cyc();
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R1 reset state
        do_reset(1'b1);
        chk(req_out_n && gnt_out_n && busy_out_n && start_n && burst_inh_n && !busy_oe && !loc_owner,
            "R1 reset", {req_out_n, gnt_out_n, busy_out_n, start_n, burst_inh_n, busy_oe, loc_owner}, 7'b1111100);

        // Arbiter role: request and need at the same edge
        loc_need = 1; req_in_n = 0; cyc();
        chk(!gnt_out_n && busy_out_n, "R3 ext wins", {gnt_out_n, busy_out_n}, 2'b01);
        busy_in_n = 0; cyc();
        chk(gnt_out_n, "R5 grant drops on busy", gnt_out_n, 1);
        req_in_n = 1; repeat (2) cyc();
        chk(busy_out_n, "R5 chip waits in tenure", busy_out_n, 1);
        busy_in_n = 1; cyc();
        chk(busy_out_n, "R5 idle after tenure", busy_out_n, 1);
        cyc();
        chk(!busy_out_n && !start_n, "R6 chip takes bus", {busy_out_n, start_n}, 0);
        req_in_n = 0; cyc();
        chk(gnt_out_n && start_n, "R4 withheld, R9 single", {gnt_out_n, start_n}, 2'b11);
        loc_last_done = 1; cyc(); loc_last_done = 0; loc_need = 0;
        chk(busy_out_n && gnt_out_n, "R10 release", {busy_out_n, gnt_out_n}, 2'b11);
        cyc();
        chk(!gnt_out_n, "R4 granted after release", gnt_out_n, 0);
        req_in_n = 1; cyc();
        chk(gnt_out_n, "R5 withdrawn request", gnt_out_n, 1);
        gnt_in_n = 0; cyc();
        chk(req_out_n && busy_out_n, "R2 gnt_in ignored", {req_out_n, busy_out_n}, 2'b11);

        // Requester role
        do_reset(1'b0);
        req_in_n = 0; loc_need = 1; cyc();
        chk(!req_out_n && gnt_out_n, "R7 request, R2 req_in ignored", {req_out_n, gnt_out_n}, 2'b01);
        gnt_in_n = 0; busy_in_n = 0; repeat (2) cyc();
        chk(!req_out_n && busy_out_n, "R7 unqualified grant", {req_out_n, busy_out_n}, 2'b01);
        busy_in_n = 1; cyc();
        chk(req_out_n && !busy_out_n && !start_n, "R8 start on qualified grant",
            {req_out_n, busy_out_n, start_n}, 3'b100);
        loc_last_done = 1; loc_need = 0; cyc(); loc_last_done = 0;
        chk(busy_out_n, "R10 release ext role", busy_out_n, 1);

        // Parked start
        do_reset(1'b0);
        gnt_in_n = 0; saw_req = 0; repeat (3) cyc();
        loc_need = 1; cyc();
        chk(!busy_out_n && !start_n && !saw_req, "R8 parked start",
            {busy_out_n, start_n, saw_req}, 3'b000);

        // Burst inhibit window edges
        do_reset(1'b1);
        ext_start_n = 0; ext_burst = 1; ext_addr = 16'h4000; cyc();
        chk(!burst_inh_n, "R11 low edge", burst_inh_n, 0);
        ext_addr = 16'h4FFF; cyc();
        chk(!burst_inh_n, "R11 high edge", burst_inh_n, 0);
        ext_addr = 16'h5000; cyc();
        chk(burst_inh_n, "R11 above window", burst_inh_n, 1);
        ext_addr = 16'h3FFF; cyc();
        chk(burst_inh_n, "R11 below window", burst_inh_n, 1);
        ext_addr = 16'h4800; ext_burst = 0; cyc();
        chk(burst_inh_n, "R11 single access", burst_inh_n, 1);
        ext_start_n = 1; ext_burst = 1; cyc();
        chk(burst_inh_n, "R11 no start", burst_inh_n, 1);

        rand_run(1'b1, 4000);
        rand_run(1'b0, 4000);

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule